// File: doc/BRIEF.md
# Privilege-Gated Event Counter Pair

This block holds two 32-bit event counters. Each counter has a control word that picks one of sixteen event lines and says in which privilege states counting is allowed. On every clock the block compares the processor's current privilege fields with the enabled state bits. If at least one enabled state matches and the selected event line is high, the counter goes up by one. Event code 0 is special: it counts every clock cycle on both counters. The other codes pick a line from that counter's own 16-bit pulse vector.

Software reaches the two counters and the two control words through a small synchronous write port with four addresses. A combinational read mux returns the word at the current address. When bit 31 of a counter is set, the counter is in overflow. If that counter's interrupt enable is also set, the level-sensitive interrupt line goes high. Counting carries on past overflow. To get an interrupt after N events, software loads the counter with 2^31 − N.

Top module: `evt_ctr_pair`

## Requirements
- R1: After reset, both counters and both control words read zero and `irq_o` is low.
- R2: Register addresses are: 0 = control of counter 0, 1 = count of counter 0, 2 = control of counter 1, 3 = count of counter 1. A write takes effect at the clock edge where `reg_we_i` is high. `reg_rdata_o` shows the addressed word combinationally. A control word keeps only bits 8:0, and bits 31:9 read as zero.
- R3: Control bits 8:5 select the event. With event code 0, an enabled counter goes up by exactly one on every clock edge, whatever its pulse vector holds.
- R4: With a nonzero event code k, a counter goes up by one at the edge where bit k of its own pulse vector is high. Other bits, and the other counter's vector, have no effect on it.
- R5: Control bit 3 enables counting when KSU=2, bit 2 when KSU=1, and bit 1 when KSU=0. Each of these also needs EXL=0 and ERL=0.
- R6: Control bit 0 enables counting when EXL=1 and ERL=0, for any KSU. In that state bits 3:1 do not match.
- R7: When ERL=1, or when KSU=3 with EXL=0, no state bit matches and the counters hold their values.
- R8: When several state bits are set, a counter counts in any state that matches at least one of them.
- R9: `irq_o` is high exactly while some counter has bit 31 set and control bit 4 (interrupt enable) set. It clears when software clears that enable bit or writes a count with bit 31 clear.
- R10: Counting continues after bit 31 is set. A counter holding all ones wraps to zero on its next count.
- R11: A write to a counter in the same cycle as a qualifying increment loads the written value, and the increment is lost.
- R12: A counter loaded with 2^31 − N under interrupt enable raises `irq_o` right after the N-th counted event, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_ksu_i | input | 2 | Current privilege level field |
| priv_exl_i | input | 1 | Exception-level flag |
| priv_erl_i | input | 1 | Error-level flag |
| evt0_i | input | 16 | Event pulses for counter 0 |
| evt1_i | input | 16 | Event pulses for counter 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Addressed register, combinational |
| cnt0_o | output | 32 | Counter 0 value |
| cnt1_o | output | 32 | Counter 1 value |
| ctl0_o | output | 32 | Counter 0 control word |
| ctl1_o | output | 32 | Counter 1 control word |
| irq_o | output | 1 | Overflow interrupt request, level |

## Verification
Writes, and increments from an event pulse or a matching privilege state, land at the first rising edge that sees them. They are visible on the outputs one edge after the stimulus is applied. `reg_rdata_o` and `irq_o` follow the stored registers in the same cycle, with no extra delay. The bench drives every input on the falling edge and checks on a later falling edge. Cycle-count tests open a counting window of a known number of edges and close it with ERL before sampling. The expected count is then exactly that number of edges.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int CNT_W  = 32;
  localparam int EVT_N  = 16;
  localparam int SEL_W  = $clog2(EVT_N);
  localparam int NCNT   = 2;
  localparam int CTL_W  = SEL_W + 5;
  localparam int ADDR_W = $clog2(2 * NCNT);

  // bit order is the software-visible layout: sel | ie | u | s | k | exl
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic             en_u;
    logic             en_s;
    logic             en_k;
    logic             en_exl;
  } ctl_t;

  localparam logic [1:0] KSU_KERN = 2'd0;
  localparam logic [1:0] KSU_SUPV = 2'd1;
  localparam logic [1:0] KSU_USER = 2'd2;
endpackage

// File: rtl/evt_priv_match.sv
module evt_priv_match
  import evt_ctr_pkg::*;
(
  input  ctl_t       ctl_i,
  input  logic [1:0] ksu_i,
  input  logic       exl_i,
  input  logic       erl_i,
  output logic       match_o
);
  logic base_lvl;
  logic [3:0] hit;

  assign base_lvl = !exl_i && !erl_i;
  assign hit[3] = ctl_i.en_u   && base_lvl && (ksu_i == KSU_USER);
  assign hit[2] = ctl_i.en_s   && base_lvl && (ksu_i == KSU_SUPV);
  assign hit[1] = ctl_i.en_k   && base_lvl && (ksu_i == KSU_KERN);
  assign hit[0] = ctl_i.en_exl && exl_i && !erl_i;
  assign match_o = |hit;
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evt_ctr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [1:0]       ksu_i,
  input  logic             exl_i,
  input  logic             erl_i,
  input  logic             ctl_we_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output ctl_t             ctl_o,
  output logic             irq_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             priv_ok;
  logic             evt_hit;

  evt_priv_match u_match (
    .ctl_i  (ctl_q),
    .ksu_i  (ksu_i),
    .exl_i  (exl_i),
    .erl_i  (erl_i),
    .match_o(priv_ok)
  );

  // code 0 is the free-running cycle event
  assign evt_hit = (ctl_q.sel == '0) ? 1'b1 : evt_i[ctl_q.sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (evt_hit && priv_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ctl_o = ctl_q;
  assign irq_o = ctl_q.ie && cnt_q[CNT_W-1];
endmodule

// File: rtl/evt_ctr_pair.sv
module evt_ctr_pair
  import evt_ctr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        priv_ksu_i,
  input  logic              priv_exl_i,
  input  logic              priv_erl_i,
  input  logic [EVT_N-1:0]  evt0_i,
  input  logic [EVT_N-1:0]  evt1_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  cnt0_o,
  output logic [CNT_W-1:0]  cnt1_o,
  output logic [CNT_W-1:0]  ctl0_o,
  output logic [CNT_W-1:0]  ctl1_o,
  output logic              irq_o
);
  logic [EVT_N-1:0] evt_arr [NCNT];
  logic [CNT_W-1:0] cnt_arr [NCNT];
  logic [CNT_W-1:0] ctl_arr [NCNT];
  logic [NCNT-1:0]  irq_vec;

  assign evt_arr[0] = evt0_i;
  assign evt_arr[1] = evt1_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_slice
    ctl_t ctl_w;
    logic sel_me;

    // addr[1] picks the counter, addr[0] picks count over control
    assign sel_me = reg_we_i && (reg_addr_i[ADDR_W-1:1] == g);

    evt_ctr_slice u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_arr[g]),
      .ksu_i   (priv_ksu_i),
      .exl_i   (priv_exl_i),
      .erl_i   (priv_erl_i),
      .ctl_we_i(sel_me && !reg_addr_i[0]),
      .cnt_we_i(sel_me && reg_addr_i[0]),
      .wdata_i (reg_wdata_i),
      .cnt_o   (cnt_arr[g]),
      .ctl_o   (ctl_w),
      .irq_o   (irq_vec[g])
    );

    assign ctl_arr[g] = {{(CNT_W-CTL_W){1'b0}}, ctl_w};
  end

  always_comb begin
    reg_rdata_o = reg_addr_i[0] ? cnt_arr[reg_addr_i[ADDR_W-1:1]]
                                : ctl_arr[reg_addr_i[ADDR_W-1:1]];
  end

  assign cnt0_o = cnt_arr[0];
  assign cnt1_o = cnt_arr[1];
  assign ctl0_o = ctl_arr[0];
  assign ctl1_o = ctl_arr[1];
  assign irq_o  = |irq_vec;
endmodule

// File: rtl/evt_ctr_pair_chk.sv
module evt_ctr_pair_chk
  import evt_ctr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        priv_ksu_i,
  input logic              priv_exl_i,
  input logic              priv_erl_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [CNT_W-1:0]  reg_wdata_i,
  input logic [CNT_W-1:0]  cnt0_o,
  input logic [CNT_W-1:0]  cnt1_o,
  input logic [CNT_W-1:0]  ctl0_o,
  input logic [CNT_W-1:0]  ctl1_o,
  input logic              irq_o
);
  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (cnt0_o == $past(cnt0_o) || cnt0_o == $past(cnt0_o) + 32'd1)); // R3

  AST_CYCLE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl0_o[8:5] == 4'd0 && ctl0_o[3] && priv_ksu_i == 2'd2 && !priv_exl_i &&
     !priv_erl_i && !(reg_we_i && !reg_addr_i[1]))
    |=> cnt0_o == $past(cnt0_o) + 32'd1); // R3

  AST_ERL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_erl_i && !reg_we_i) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R7

  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2)
    |=> ctl1_o == {23'd0, $past(reg_wdata_i[8:0])}); // R2

  AST_CTL0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0)
    |=> ctl0_o == {23'd0, $past(reg_wdata_i[8:0])}); // R2

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3) |=> cnt1_o == $past(reg_wdata_i)); // R11

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ctl0_o[4] && cnt0_o[31]) || (ctl1_o[4] && cnt1_o[31]))); // R9

  AST_IRQ_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i && cnt0_o != '1 && cnt1_o != '1) |=> irq_o); // R10
endmodule

bind evt_ctr_pair evt_ctr_pair_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .priv_ksu_i (priv_ksu_i),
  .priv_exl_i (priv_exl_i),
  .priv_erl_i (priv_erl_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .cnt0_o     (cnt0_o),
  .cnt1_o     (cnt1_o),
  .ctl0_o     (ctl0_o),
  .ctl1_o     (ctl1_o),
  .irq_o      (irq_o)
);

// File: tb/evt_ctr_pair_tb_top.sv
module evt_ctr_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ksu = 2'd0;
  logic        exl = 1'b0;
  logic        erl = 1'b1;
  logic [15:0] evt0 = '0;
  logic [15:0] evt1 = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cnt0, cnt1, ctl0, ctl1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_ctr_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .priv_ksu_i(ksu), .priv_exl_i(exl),
    .priv_erl_i(erl), .evt0_i(evt0), .evt1_i(evt1), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cnt0_o(cnt0), .cnt1_o(cnt1), .ctl0_o(ctl0), .ctl1_o(ctl1), .irq_o(irq)
  );

  localparam logic [31:0] M_U = 32'h8, M_S = 32'h4, M_K = 32'h2, M_X = 32'h1, IE = 32'h10;

  function automatic logic [31:0] ctl_w(input int ev, input logic [31:0] bits);
    return (32'(ev) << 5) | bits;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse0(input int b);
    @(negedge clk);
    evt0 = 16'(1 << b);
    @(negedge clk);
    evt0 = '0;
  endtask

  task automatic set_priv(input logic [1:0] k, input logic x, input logic r);
    @(negedge clk);
    ksu = k; exl = x; erl = r;
  endtask

  task automatic t_reset();
    check("R1 cnt0", cnt0, 0);
    check("R1 cnt1", cnt1, 0);
    check("R1 ctl0", ctl0, 0);
    check("R1 ctl1", ctl1, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    addr = 2'd0; #1;
    check("R2 ctl0 pad bits", rdata, 32'h1FF);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1234_5678);
    addr = 2'd3; #1;
    check("R2 cnt1 readback", rdata, 32'h1234_5678);
    wr(2'd2, ctl_w(3, M_K));
    addr = 2'd2; #1;
    check("R2 ctl1 readback", rdata, ctl_w(3, M_K));
    wr(2'd2, 0);
    wr(2'd3, 0);
  endtask

  task automatic t_select();
    set_priv(2'd2, 0, 0);
    wr(2'd1, 0);
    wr(2'd0, ctl_w(5, M_U));
    wr(2'd2, ctl_w(5, M_U));
    for (int i = 0; i < 3; i++) pulse0(5);
    for (int i = 0; i < 2; i++) pulse0(6);
    pulse0(0);
    check("R4 cnt0 own bit only", cnt0, 3);
    check("R4 cnt1 ignores evt0", cnt1, 0);
    @(negedge clk); evt1 = 16'h0020;
    @(negedge clk); evt1 = '0;
    check("R4 cnt1 own vector", cnt1, 1);
    check("R4 cnt0 ignores evt1", cnt0, 3);
    wr(2'd0, 0); wr(2'd2, 0); wr(2'd1, 0); wr(2'd3, 0);
  endtask

  task automatic t_cycles();
    set_priv(2'd0, 0, 1);
    wr(2'd2, ctl_w(0, M_K));
    evt1 = '0;
    @(negedge clk); erl = 1'b0;
    repeat (7) @(negedge clk);
    erl = 1'b1;
    check("R3 cycle event count", cnt1, 7);
    repeat (3) @(negedge clk);
    check("R7 erl holds count", cnt1, 7);
    wr(2'd2, 0); wr(2'd3, 0);
  endtask

  task automatic try_mode(input string req, input logic [31:0] bits,
                          input logic [1:0] k, input logic x, input logic r,
                          input logic [31:0] exp);
    wr(2'd0, 0);
    wr(2'd1, 0);
    set_priv(k, x, r);
    wr(2'd0, ctl_w(0, bits));
    repeat (4) @(negedge clk);
    erl = 1'b1;
    check(req, cnt0, exp);
    wr(2'd0, 0);
  endtask

  task automatic t_modes();
    try_mode("R5 U in user", M_U, 2'd2, 0, 0, 4);
    try_mode("R5 U not in kernel", M_U, 2'd0, 0, 0, 0);
    try_mode("R5 S in supervisor", M_S, 2'd1, 0, 0, 4);
    try_mode("R5 K in kernel", M_K, 2'd0, 0, 0, 4);
    try_mode("R6 K not under exl", M_K, 2'd0, 1, 0, 0);
    try_mode("R6 EXL bit under exl", M_X, 2'd2, 1, 0, 4);
    try_mode("R7 erl blocks all", M_U | M_S | M_K | M_X, 2'd2, 1, 1, 0);
    try_mode("R7 ksu3 matches none", M_U | M_S | M_K, 2'd3, 0, 0, 0);
    try_mode("R8 U|K in kernel", M_U | M_K, 2'd0, 0, 0, 4);
    try_mode("R8 U|K in user", M_U | M_K, 2'd2, 0, 0, 4);
  endtask

  task automatic t_write_prio();
    set_priv(2'd2, 0, 0);
    wr(2'd0, ctl_w(0, M_U));
    wr(2'd1, 32'd100);
    check("R11 write beats increment", cnt0, 100);
    @(negedge clk);
    check("R11 count resumes", cnt0, 101);
    erl = 1'b1;
    wr(2'd0, 0); wr(2'd1, 0);
  endtask

  task automatic t_overflow();
    set_priv(2'd2, 0, 1);
    wr(2'd0, ctl_w(7, M_U | IE));
    wr(2'd1, 32'h8000_0000 - 3);
    erl = 1'b0;
    pulse0(7); pulse0(7);
    check("R12 no irq before N", 32'(irq), 0);
    check("R12 count at N-1", cnt0, 32'h7FFF_FFFF);
    pulse0(7);
    check("R12 irq at N", 32'(irq), 1);
    pulse0(7);
    check("R10 count past overflow", cnt0, 32'h8000_0001);
    check("R9 irq level holds", 32'(irq), 1);
    wr(2'd0, ctl_w(7, M_U));
    check("R9 irq off without ie", 32'(irq), 0);
    wr(2'd0, ctl_w(7, M_U | IE));
    check("R9 irq back with ie", 32'(irq), 1);
    wr(2'd1, 32'd5);
    check("R9 irq cleared by write", 32'(irq), 0);
    wr(2'd1, 32'hFFFF_FFFF);
    pulse0(7);
    check("R10 wrap to zero", cnt0, 0);
    erl = 1'b1;
    wr(2'd3, 32'h8000_0000);
    check("R9 no irq cnt1 without ie", 32'(irq), 0);
    wr(2'd2, ctl_w(1, IE));
    check("R9 irq from cnt1", 32'(irq), 1);
    wr(2'd2, 0); wr(2'd3, 0); wr(2'd0, 0); wr(2'd1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_select();
    t_cycles();
    t_modes();
    t_write_prio();
    t_overflow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule